// File: doc/BRIEF.md
# Partial reconfiguration bitstream intake controller

This block is a memory-mapped slave through which a host processor pushes a partial-reconfiguration image into the fabric. It has two 32-bit registers. A control/status register holds a start flag and a 3-bit result code that software polls. A data port takes every bitstream word at the same address. Accepted words leave the block on a valid/ready stream toward the configuration port. The bus write is held with a wait signal while that port is not ready.

Software first sets the start flag and then writes the image word by word. An image whose byte length is not a multiple of four ends with a word whose unused upper bytes are zero, and that word is forwarded unchanged. A side input gives the total word count. The last word carries the complement of a CRC-32 taken over all the words before it. One cycle after the last word is accepted, the block reports success or a CRC failure, so a polling loop with a timeout always terminates. A fault pulse from the configuration port, or a data write that arrives outside a transfer, ends the transfer with an error code.

Top module: `pr_intake`

## Requirements
- R1: While rst_n is low, and until the first clock edge after the two-stage reset release, the start flag is 0 and the status code is 0 (idle).
- R2: The control/status register sits at byte offset 0x04. Bit 0 is the start flag, bits [4:2] are the status code, and all other bits read 0. Status codes: 0 idle, 1 general error, 2 CRC mismatch, 3 stream fault, 4 in progress, 5 success. Writing 1 to bit 0 while the flag is clear sets the flag and status 4 from any other code. Writing 0 to bit 0 has no effect.
- R3: A write of 1 to bit 0 while the start flag is already set is ignored: the flag stays set, status stays 4, and the transfer continues where it was.
- R4: The data port sits at byte offset 0x00 and reads as 0. While status is 4, a write there raises cfg_valid with cfg_data equal to the written word. bus_wait is high for as long as cfg_ready is low. A word counts only in the cycle in which it is accepted (cfg_valid and cfg_ready both high).
- R5: A data write while status is not 4 is dropped: cfg_valid stays low and status becomes 1.
- R6: The accepted word whose count reaches word_total is the last word (a word_total of 0 acts as 1). The CRC-32 uses polynomial 0x04C11DB7, seed 0xFFFFFFFF, and processes each word MSB first. It covers every earlier word of the transfer. If the last word equals the bitwise complement of that CRC, status becomes 5; otherwise it becomes 2. Either way, the start flag clears on the next edge.
- R7: A cfg_fault pulse while status is 4 sets status 3 and clears the start flag. It takes precedence over a last word accepted in the same cycle.
- R8: Any other byte offset, including a misaligned one, reads as 0, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle bus_rd is high |
| bus_wait | output | 1 | Holds the current data write until the stream accepts it |
| word_total | input | CNT_W | Number of words in the image, including the CRC word |
| cfg_data | output | 32 | Bitstream word toward the configuration port |
| cfg_valid | output | 1 | cfg_data holds a word |
| cfg_ready | input | 1 | Configuration port accepts the word |
| cfg_fault | input | 1 | Fault pulse from the configuration port |

## Verification
Several properties are checked on every cycle:
- the stall rule between cfg_valid, cfg_ready and bus_wait;
- that words are never forwarded outside a transfer;
- that a data write outside a transfer forces code 1;
- that a fault during a transfer forces code 3;
- that a repeated start leaves the transfer running;
- that the start flag is tied to code 4.

Other behaviour can only be shown by the bench's scenarios, because it depends on a whole sequence of writes:
- the CRC verdict after a full image;
- counting of words that are held back by backpressure;
- the zero-word-count corner;
- fault-over-verdict precedence;
- reset in the middle of a transfer;
- unmapped and misaligned offsets.

// File: rtl/pr_intake_pkg.sv
package pr_intake_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_FAIL       = 3'd1,
    ST_CRC_BAD    = 3'd2,
    ST_STREAM_BAD = 3'd3,
    ST_BUSY       = 3'd4,
    ST_DONE       = 3'd5
  } pr_status_e;

  localparam logic [WORD_W-1:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [WORD_W-1:0] CRC_SEED = 32'hFFFF_FFFF;

  // One whole word folded into the running CRC, most significant bit first.
  function automatic logic [WORD_W-1:0] crc_fold(input logic [WORD_W-1:0] acc,
                                                 input logic [WORD_W-1:0] word);
    logic [WORD_W-1:0] c;
    logic              fb;
    c = acc;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      fb = c[WORD_W-1] ^ word[i];
      c  = {c[WORD_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
    return c;
  endfunction

endpackage

// File: rtl/pr_bus_decode.sv
module pr_bus_decode #(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              sel_data,
  output logic              sel_csr
);
  localparam logic [ADDR_W-1:0] OFS_DATA = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_CSR  = ADDR_W'(4);

  // Exact match on all bits: misaligned offsets fall outside the map.
  always_comb begin
    sel_data = (addr == OFS_DATA);
    sel_csr  = (addr == OFS_CSR);
  end
endmodule

// File: rtl/pr_crc_acc.sv
module pr_crc_acc
  import pr_intake_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              update,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] crc_q
);
  logic [WORD_W-1:0] crc_n;
  logic              crc_en;

  always_comb begin
    crc_en = clear | update;
    if (clear) crc_n = CRC_SEED;
    else       crc_n = crc_fold(crc_q, word);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= CRC_SEED;
    else if (crc_en) crc_q <= crc_n;
  end
endmodule

// File: rtl/pr_xfer_ctrl.sv
module pr_xfer_ctrl
  import pr_intake_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             data_wr,
  input  logic             accept,
  input  logic             fault,
  input  logic             final_ok,
  input  logic [CNT_W-1:0] word_total,
  output pr_status_e       status_q,
  output logic             start_q,
  output logic             busy,
  output logic             crc_clear,
  output logic             crc_update
);
  localparam int CMP_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CMP_W-1:0] cnt_plus;
  logic             is_last;
  logic             cnt_en, state_en;
  pr_status_e       status_n;
  logic             start_n;

  always_comb begin
    busy     = (status_q == ST_BUSY);
    cnt_plus = {1'b0, cnt_q} + CMP_W'(1);
    is_last  = (cnt_plus >= {1'b0, word_total});
  end

  always_comb begin
    status_n   = status_q;
    start_n    = start_q;
    cnt_n      = cnt_q;
    cnt_en     = 1'b0;
    crc_clear  = 1'b0;
    crc_update = 1'b0;
    if (start_req && !start_q) begin
      status_n  = ST_BUSY;
      start_n   = 1'b1;
      cnt_n     = '0;
      cnt_en    = 1'b1;
      crc_clear = 1'b1;
    end else if (data_wr && !busy) begin
      status_n = ST_FAIL;
    end else if (busy && fault) begin
      status_n = ST_STREAM_BAD;
      start_n  = 1'b0;
    end else if (accept) begin
      if (is_last) begin
        status_n = final_ok ? ST_DONE : ST_CRC_BAD;
        start_n  = 1'b0;
      end else begin
        cnt_n      = cnt_q + CNT_W'(1);
        cnt_en     = 1'b1;
        crc_update = 1'b1;
      end
    end
    state_en = (status_n != status_q) || (start_n != start_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= ST_IDLE;
      start_q  <= 1'b0;
    end else if (state_en) begin
      status_q <= status_n;
      start_q  <= start_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end
endmodule

// File: rtl/pr_intake.sv
module pr_intake
  import pr_intake_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_wait,
  input  logic [CNT_W-1:0]  word_total,
  output logic [31:0]       cfg_data,
  output logic              cfg_valid,
  input  logic              cfg_ready,
  input  logic              cfg_fault
);
  localparam int PAD_W = WORD_W - 5;

  logic [1:0]        rst_sync_q;
  logic              rst_core_n;
  logic              sel_data, sel_csr;
  logic              data_wr, start_req, accept, final_ok, busy;
  logic              crc_clear, crc_update;
  logic [WORD_W-1:0] crc_q;
  pr_status_e        status_q;
  logic              start_q;

  // Reset asserts at once and leaves two edges after rst_n rises.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  pr_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr     (bus_addr),
    .sel_data (sel_data),
    .sel_csr  (sel_csr)
  );

  always_comb begin
    data_wr   = bus_wr & sel_data;
    start_req = bus_wr & sel_csr & bus_wdata[0];
    cfg_valid = data_wr & busy;
    cfg_data  = bus_wdata;
    accept    = cfg_valid & cfg_ready;
    bus_wait  = cfg_valid & ~cfg_ready;
    final_ok  = (bus_wdata == ~crc_q);
  end

  pr_crc_acc u_crc (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .clear  (crc_clear),
    .update (crc_update),
    .word   (bus_wdata),
    .crc_q  (crc_q)
  );

  pr_xfer_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .start_req  (start_req),
    .data_wr    (data_wr),
    .accept     (accept),
    .fault      (cfg_fault),
    .final_ok   (final_ok),
    .word_total (word_total),
    .status_q   (status_q),
    .start_q    (start_q),
    .busy       (busy),
    .crc_clear  (crc_clear),
    .crc_update (crc_update)
  );

  always_comb begin
    if (bus_rd && sel_csr) bus_rdata = {{PAD_W{1'b0}}, status_q, 1'b0, start_q};
    else                   bus_rdata = '0;
  end
endmodule

// File: rtl/pr_intake_chk.sv
module pr_intake_chk
  import pr_intake_pkg::*;
(
  input logic       clk,
  input logic       rst_core_n,
  input logic       bus_wr,
  input logic       sel_data,
  input logic       sel_csr,
  input logic       bus_wait,
  input logic       cfg_valid,
  input logic       cfg_ready,
  input logic       cfg_fault,
  input pr_status_e status_q,
  input logic       start_q
);
  a_r4_stall_holds_bus: assert property (@(posedge clk) disable iff (!rst_core_n)
    (cfg_valid && !cfg_ready) |-> bus_wait);

  a_r4_no_wait_when_ready: assert property (@(posedge clk) disable iff (!rst_core_n)
    cfg_ready |-> !bus_wait);

  a_r5_no_forward_outside: assert property (@(posedge clk) disable iff (!rst_core_n)
    cfg_valid |-> (status_q == ST_BUSY));

  a_r5_stray_data_error: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_wr && sel_data && status_q != ST_BUSY) |=> (status_q == ST_FAIL));

  a_r3_restart_ignored: assert property (@(posedge clk) disable iff (!rst_core_n)
    (start_q && bus_wr && sel_csr && !cfg_fault) |=> (start_q && status_q == ST_BUSY));

  a_r7_fault_ends: assert property (@(posedge clk) disable iff (!rst_core_n)
    (status_q == ST_BUSY && cfg_fault) |=> (status_q == ST_STREAM_BAD && !start_q));

  a_r2_flag_tracks_busy: assert property (@(posedge clk) disable iff (!rst_core_n)
    start_q == (status_q == ST_BUSY));

  a_r2_code_range: assert property (@(posedge clk) disable iff (!rst_core_n)
    status_q <= ST_DONE);
endmodule

bind pr_intake pr_intake_chk u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .bus_wr     (bus_wr),
  .sel_data   (sel_data),
  .sel_csr    (sel_csr),
  .bus_wait   (bus_wait),
  .cfg_valid  (cfg_valid),
  .cfg_ready  (cfg_ready),
  .cfg_fault  (cfg_fault),
  .status_q   (status_q),
  .start_q    (start_q)
);

// File: tb/pr_intake_test.sv
module pr_intake_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 4;
  localparam int CNT_W  = 16;
  localparam int NVEC   = 14;

  // {op[2:0], data[31:0], expected status[2:0]}
  // op: 0 control write, 1 data write, 2 correct CRC word, 3 wrong CRC word, 4 fault pulse
  localparam logic [37:0] VEC [0:NVEC-1] = '{
    {3'd1, 32'h0000_0011, 3'd1},
    {3'd0, 32'h0000_0001, 3'd4},
    {3'd1, 32'hA5A5_A5A5, 3'd4},
    {3'd0, 32'h0000_0001, 3'd4},
    {3'd1, 32'h1234_5678, 3'd4},
    {3'd2, 32'h0000_0000, 3'd5},
    {3'd0, 32'h0000_0000, 3'd5},
    {3'd0, 32'hFFFF_FFFF, 3'd4},
    {3'd1, 32'h0000_0001, 3'd4},
    {3'd1, 32'h00C0_FFEE, 3'd4},
    {3'd3, 32'h0000_0000, 3'd2},
    {3'd0, 32'h0000_0001, 3'd4},
    {3'd4, 32'h0000_0000, 3'd3},
    {3'd1, 32'h0000_00FF, 3'd1}
  };

  logic              clk;
  logic              rst_n;
  logic [ADDR_W-1:0] bus_addr;
  logic              bus_wr, bus_rd;
  logic [31:0]       bus_wdata, bus_rdata;
  logic              bus_wait;
  logic [CNT_W-1:0]  word_total;
  logic [31:0]       cfg_data;
  logic              cfg_valid, cfg_ready, cfg_fault;

  int checks = 0;
  int errors = 0;

  pr_intake #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uut (
    .clk, .rst_n, .bus_addr, .bus_wr, .bus_rd, .bus_wdata, .bus_rdata,
    .bus_wait, .word_total, .cfg_data, .cfg_valid, .cfg_ready, .cfg_fault
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [31:0] w);
    logic [31:0] r;
    r = c;
    for (int b = 31; b >= 0; b--) begin
      if (r[31] != w[b]) r = (r << 1) ^ 32'h04C11DB7;
      else               r = r << 1;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic wr_data(input logic [31:0] d, output logic fwd, output logic [31:0] fdat);
    @(negedge clk);
    bus_addr = '0; bus_wdata = d; bus_wr = 1'b1;
    #1;
    fwd = cfg_valid; fdat = cfg_data;
    while (bus_wait) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [ADDR_W-1:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    v = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic expect_csr(input logic [2:0] st, input string req);
    logic [31:0] v, e;
    rd_reg(4'h4, v);
    e = {27'd0, st, 1'b0, (st == 3'd4)};
    check(v == e, req, v, e);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic        busy_m, fwd;
    logic [31:0] crc_m, w, fdat, v;
    logic [2:0]  op;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    word_total = 16'd3; cfg_ready = 1'b1; cfg_fault = 1'b0;
    busy_m = 1'b0; crc_m = 32'hFFFF_FFFF;
    do_reset();

    // R1: reset state; R4: data port reads zero
    expect_csr(3'd0, "R1 reset state");
    rd_reg(4'h0, v);
    check(v == 32'd0, "R4 data port reads zero", v, 32'd0);

    // R8: unmapped and misaligned offsets
    wr_reg(4'h8, 32'h1);
    wr_reg(4'h5, 32'h1);
    expect_csr(3'd0, "R8 unmapped writes no effect");
    rd_reg(4'h8, v);
    check(v == 32'd0, "R8 unmapped read zero", v, 32'd0);

    // Table walk: R2 R3 R5 R6 R7
    for (int k = 0; k < NVEC; k++) begin
      op = VEC[k][37:35];
      w  = VEC[k][34:3];
      case (op)
        3'd0: begin
          wr_reg(4'h4, w);
          if (w[0] && !busy_m) crc_m = 32'hFFFF_FFFF;
        end
        3'd4: begin
          @(negedge clk); cfg_fault = 1'b1;
          @(posedge clk); #1; cfg_fault = 1'b0;
        end
        default: begin
          if (op == 3'd2) w = ~crc_m;
          if (op == 3'd3) w = ~crc_m ^ 32'h1;
          wr_data(w, fwd, fdat);
          check(fwd == busy_m, "R5 forward only during transfer", {31'd0, fwd}, {31'd0, busy_m});
          if (busy_m) begin
            check(fdat == w, "R4 forwarded word", fdat, w);
            if (op == 3'd1) crc_m = ref_crc(crc_m, w);
          end
        end
      endcase
      expect_csr(VEC[k][2:0], "R2 R3 R5 R6 R7 table step");
      busy_m = (VEC[k][2:0] == 3'd4);
    end

    // R4: backpressure, word counted once
    word_total = 16'd2;
    wr_reg(4'h4, 32'h1);
    cfg_ready = 1'b0;
    @(negedge clk);
    bus_addr = '0; bus_wdata = 32'hDEAD_BEEF; bus_wr = 1'b1;
    #1;
    check(bus_wait == 1'b1, "R4 wait while not ready", {31'd0, bus_wait}, 32'd1);
    repeat (2) @(negedge clk);
    #1;
    check(bus_wait == 1'b1 && cfg_valid == 1'b1, "R4 wait holds", {31'd0, bus_wait}, 32'd1);
    cfg_ready = 1'b1;
    #1;
    check(bus_wait == 1'b0, "R4 wait drops when ready", {31'd0, bus_wait}, 32'd0);
    @(posedge clk); #1;
    bus_wr = 1'b0;
    expect_csr(3'd4, "R4 still in progress after one word");
    wr_data(~ref_crc(32'hFFFF_FFFF, 32'hDEAD_BEEF), fwd, fdat);
    expect_csr(3'd5, "R4 R6 stalled word counted once");

    // R6: word_total of zero acts as one; CRC of nothing complements to zero
    word_total = 16'd0;
    wr_reg(4'h4, 32'h1);
    wr_data(32'h0, fwd, fdat);
    expect_csr(3'd5, "R6 zero count single word");

    // R7: fault beats the verdict on the last word
    word_total = 16'd1;
    wr_reg(4'h4, 32'h1);
    @(negedge clk);
    bus_addr = '0; bus_wdata = 32'h0; bus_wr = 1'b1; cfg_fault = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0; cfg_fault = 1'b0;
    expect_csr(3'd3, "R7 fault precedence");

    // R1: reset in the middle of a transfer
    word_total = 16'd4;
    wr_reg(4'h4, 32'h1);
    wr_data(32'h55, fwd, fdat);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    rd_reg(4'h4, v);
    check(v == 32'd0, "R1 reset asserts at once", v, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    expect_csr(3'd0, "R1 state after mid-transfer reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule